// File: doc/BRIEF.md
# Serial SRAM Slave with Mode-Selected Address Stepping

This block behaves as a byte-wide static memory that is reached over a four-wire serial link. The link has a serial clock, an active-low select, one data line in and one data line out. An active-low pause input is also present. Every link input is brought into the fast system clock domain through a two-stage synchronizer. The serial clock is then turned into rise and fall strobes. Input bits are captured on serial clock rises and output bits change after serial clock falls, most significant bit first. The system clock must run at least four times faster than the serial clock.

Each select-low period starts with an 8-bit instruction. There are four instructions. READ (0x03) and WRITE (0x02) are followed by a 16-bit address, and only the low `ADDR_W` bits of that address are used. RDSR (0x05) returns the status byte and WRSR (0x01) loads it. Status bits [7:6] choose how the internal pointer moves after each data byte:

- one byte only (00, the reset value; 11 acts the same),
- stay inside a 32-byte page (10),
- run linearly through the whole array (01).

Status bit 0 set to 1 switches the pause input off.

The control state machine has eight states:

| State | Role | Leaves when |
|---|---|---|
| ST_IDLE | Standby | A fresh select fall moves it to ST_CMD |
| ST_CMD | Gathers the instruction | After 8 bits: ST_ADDR for READ/WRITE, ST_SR_RD for RDSR, ST_SR_WR for WRSR, ST_DONE for an unknown code |
| ST_ADDR | Gathers 16 address bits | Goes to ST_RD or ST_WR |
| ST_RD / ST_WR | Move data bytes | Go to ST_DONE after one byte in byte mode |
| ST_SR_RD / ST_SR_WR | Move the status byte | Go to ST_DONE after 8 bits |
| ST_DONE | Ignores the link | Waits for deselect |

A high select sends every state back to ST_IDLE.

Top module: `sram_spi_slave`

## Requirements
- R1: After reset, standby is 1 and ser_out_en is 0. A select that is already low when reset ends starts nothing; an operation needs a select high-to-low transition seen after reset.
- R2: READ (0x03) followed by a 16-bit address returns the stored byte MSB first. The bit changes after a serial clock fall and is valid at the next rise. Address bits above ADDR_W are ignored, and ser_out_en is 1 while data is being shifted out.
- R3: WRITE (0x02) followed by a 16-bit address and a data byte sampled MSB first on serial clock rises stores that byte at the address.
- R4: In byte mode (status[7:6]=00, the reset value, with 11 treated alike) one data byte is moved. Later clocks in the same select period write nothing and leave ser_out_en at 0.
- R5: In page mode (status[7:6]=10) the pointer steps after each byte and wraps from byte 31 of a 32-byte page to byte 0 of the same page.
- R6: In sequential mode (status[7:6]=01) the pointer crosses page boundaries and rolls over from the top address (2^ADDR_W-1) to 0.
- R7: RDSR (0x05) returns {status[7:6], 0000, 1, status[0]}, which is 0x02 after reset. WRSR (0x01) loads status[7:6] and status[0] from the byte sent.
- R8: An undefined instruction byte makes the block ignore the rest of the select period, with ser_out_en at 0 and memory unchanged.
- R9: With status[0]=0, pause_n taken low while the serial clock is low drives ser_out_en to 0 and makes serial clock edges have no effect. Releasing it with the clock low resumes the transfer at the exact bit where it stopped.
- R10: A pause_n change made while the serial clock is high takes effect only after the next serial clock fall, and that fall is still acted on.
- R11: With status[0]=1, pause_n is ignored and transfers continue.
- R12: Taking select high during any operation ends it. Within a few system clocks ser_out_en goes to 0 and standby goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host (idle low) |
| sel_n | input | 1 | Active-low device select |
| ser_in | input | 1 | Serial data from the host |
| pause_n | input | 1 | Active-low transfer pause |
| ser_out | output | 1 | Serial data to the host |
| ser_out_en | output | 1 | Drive enable for ser_out; 0 models high impedance |
| standby | output | 1 | 1 while deselected and idle |

## Verification
The hardest case to reach is a pause asked for while the serial clock is high. The request must be held back, and the clock fall that follows must still shift out the next bit before the pause freezes anything. The bench reaches this case inside a read that has already started. It raises the serial clock by hand, drops pause_n, and checks that the output is still enabled. It then lowers the clock and checks that the output is now off. Next it sends clock pulses that must be ignored, releases the pause with the clock low, and checks that the rest of the byte arrives whole.

// File: rtl/spisram_pkg.sv
package spisram_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_SEQ  = 2'b01,
        MODE_PAGE = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_SR_RD,
        ST_SR_WR,
        ST_DONE
    } state_e;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;

endpackage

// File: rtl/spisram_sync.sv
module spisram_sync #(
    parameter int          STAGES  = 2,
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[i]};
            end
        end
        assign dout[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/spisram_step.sv
module spisram_step
    import spisram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    always_comb begin
        unique case (mode)
            MODE_PAGE: nxt = {cur[ADDR_W-1:PAGE_W], PAGE_W'(cur[PAGE_W-1:0] + 1'b1)};
            MODE_SEQ:  nxt = ADDR_W'(cur + 1'b1);
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/spisram_array.sv
module spisram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave
    import spisram_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic sel_n,
    input  logic ser_in,
    input  logic pause_n,
    output logic ser_out,
    output logic ser_out_en,
    output logic standby
);

    localparam int SH_W = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;

    // synchronized link inputs: {pause_n, ser_in, sel_n, ser_clk}
    logic [3:0] sync_q;
    logic       sck_s, sel_s, si_s, pause_s;

    spisram_sync #(
        .STAGES (SYNC_STAGES),
        .N      (4),
        .RST_VAL(4'b1000)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pause_n, ser_in, sel_n, ser_clk}),
        .dout (sync_q)
    );

    assign sck_s   = sync_q[0];
    assign sel_s   = sync_q[1];
    assign si_s    = sync_q[2];
    assign pause_s = sync_q[3];

    state_e            state, state_d;
    mode_e             mode_q;
    logic              hold_dis_q;
    logic              sck_prev, sel_prev, hold_q;
    logic [3:0]        cnt;
    logic [SH_W-1:0]   sh;
    logic              is_read;
    logic [ADDR_W-1:0] ptr, ptr_nxt;
    logic [7:0]        out_sh;
    logic [7:0]        mem_rdata;
    logic              mem_we;

    logic       sck_rise, sck_fall, sel_fall;
    logic       one_shot, byte_end, active;
    logic [7:0] cmd_word, sr_word;

    assign sck_rise = sck_s & ~sck_prev & ~hold_q;
    assign sck_fall = ~sck_s & sck_prev & ~hold_q;
    assign sel_fall = ~sel_s & sel_prev;
    assign cmd_word = {sh[6:0], si_s};
    assign sr_word  = {mode_q, 4'b0000, 1'b1, hold_dis_q};
    assign one_shot = (mode_q == MODE_BYTE) || (mode_q == MODE_RSVD);
    assign byte_end = sck_rise && (cnt == 4'd7);
    assign active   = (state != ST_IDLE) && (state != ST_DONE);

    spisram_step #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_step (
        .mode(mode_q),
        .cur (ptr),
        .nxt (ptr_nxt)
    );

    spisram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_array (
        .clk  (clk),
        .we   (mem_we),
        .addr (ptr),
        .wdata(cmd_word),
        .rdata(mem_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (sel_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (sel_fall) state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_end) begin
                        unique case (cmd_word)
                            OP_READ, OP_WRITE: state_d = ST_ADDR;
                            OP_RDSR:           state_d = ST_SR_RD;
                            OP_WRSR:           state_d = ST_SR_WR;
                            default:           state_d = ST_DONE;
                        endcase
                    end
                end
                ST_ADDR: if (sck_rise && cnt == 4'd15) state_d = is_read ? ST_RD : ST_WR;
                ST_RD, ST_WR: if (byte_end && one_shot) state_d = ST_DONE;
                ST_SR_RD, ST_SR_WR: if (byte_end) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev   <= 1'b0;
            sel_prev   <= 1'b0;
            hold_q     <= 1'b0;
            cnt        <= '0;
            sh         <= '0;
            is_read    <= 1'b0;
            ptr        <= '0;
            out_sh     <= '0;
            mode_q     <= MODE_BYTE;
            hold_dis_q <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            sel_prev <= sel_s;

            if (sel_s) begin
                hold_q <= 1'b0;
            end else if (!sck_s) begin
                hold_q <= ~pause_s & ~hold_dis_q;
            end

            if (sel_s) begin
                cnt <= '0;
            end else if (sck_rise && active) begin
                if (state == ST_ADDR) begin
                    cnt <= cnt + 4'd1;
                end else begin
                    cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                end
            end

            if (sck_rise) begin
                sh <= {sh[SH_W-2:0], si_s};
            end

            if (state == ST_CMD && byte_end) begin
                is_read <= (cmd_word == OP_READ);
            end

            if (state == ST_ADDR && sck_rise && cnt == 4'd15) begin
                ptr <= {sh[ADDR_W-2:0], si_s};
            end else if ((state == ST_RD || state == ST_WR) && byte_end) begin
                ptr <= ptr_nxt;
            end

            if (sck_fall && (state == ST_RD || state == ST_SR_RD)) begin
                if (cnt == 4'd0) begin
                    out_sh <= (state == ST_RD) ? mem_rdata : sr_word;
                end else begin
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end

            if (state == ST_SR_WR && byte_end) begin
                mode_q     <= mode_e'(cmd_word[7:6]);
                hold_dis_q <= cmd_word[0];
            end
        end
    end

    // outputs
    always_comb begin
        ser_out    = out_sh[7];
        ser_out_en = (state == ST_RD || state == ST_SR_RD) && !hold_q && !sel_s;
        standby    = (state == ST_IDLE);
        mem_we     = (state == ST_WR) && byte_end && !sel_s;
    end

    // ---------------- assertions ----------------
    a_r12_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (standby && !ser_out_en));

    a_r4_byte_once: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD || state == ST_WR) && mode_q == MODE_BYTE && byte_end && !sel_s)
        |=> (state == ST_DONE));

    a_r8_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && byte_end && !sel_s && cmd_word != OP_READ &&
         cmd_word != OP_WRITE && cmd_word != OP_RDSR && cmd_word != OP_WRSR)
        |=> (state == ST_DONE && !ser_out_en));

    a_r5_page_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD || state == ST_WR) && mode_q == MODE_PAGE && byte_end && !sel_s)
        |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
             ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

    a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD || state == ST_WR) && mode_q == MODE_SEQ && byte_end && !sel_s)
        |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !sel_s) |=> ($stable(cnt) && $stable(ptr) && $stable(out_sh)));

    a_r10_hold_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_q) |-> ($past(!sck_s) || $past(sel_s)));

endmodule

// File: tb/sram_spi_slave_tb.sv
module sram_spi_slave_tb;

    localparam int H = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic sel_n = 1'b0;
    logic ser_in = 1'b0;
    logic pause_n = 1'b1;
    logic ser_out, ser_out_en, standby;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit oe_seen;

    always #5 clk = ~clk;

    sram_spi_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .sel_n     (sel_n),
        .ser_in    (ser_in),
        .pause_n   (pause_n),
        .ser_out   (ser_out),
        .ser_out_en(ser_out_en),
        .standby   (standby)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic tx, output logic rx);
        ser_in = tx;
        wait_clk(H);
        rx = ser_out;
        if (ser_out_en) oe_seen = 1'b1;
        ser_clk = 1'b1;
        wait_clk(H);
        ser_clk = 1'b0;
    endtask

    task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic cs_on();
        sel_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic cs_off();
        wait_clk(H);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [15:0] addr);
        logic [7:0] d;
        byte_xfer(op, d);
        byte_xfer(addr[15:8], d);
        byte_xfer(addr[7:0], d);
    endtask

    task automatic wr_bytes(input logic [15:0] addr, input int n, input logic [31:0] data);
        logic [7:0] d;
        cs_on();
        send_hdr(8'h02, addr);
        for (int k = 0; k < n; k++) byte_xfer(data[31-8*k -: 8], d);
        cs_off();
    endtask

    task automatic rd_check(input string req, input logic [15:0] addr, input int n,
                            input logic [31:0] exp);
        logic [7:0] d;
        cs_on();
        send_hdr(8'h03, addr);
        for (int k = 0; k < n; k++) begin
            byte_xfer(8'h00, d);
            chk(req, {24'd0, d}, {24'd0, exp[31-8*k -: 8]});
        end
        cs_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_on();
        byte_xfer(8'h01, d);
        byte_xfer(v, d);
        cs_off();
    endtask

    task automatic rdsr_check(input string req, input logic [7:0] exp);
        logic [7:0] d;
        cs_on();
        byte_xfer(8'h05, d);
        byte_xfer(8'h00, d);
        chk(req, {24'd0, d}, {24'd0, exp});
        cs_off();
    endtask

    // R1: reset state and no start without a fresh select fall
    task automatic t_reset();
        logic [7:0] d;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R1 standby after reset", {31'd0, standby}, 32'd1);
        chk("R1 oe after reset", {31'd0, ser_out_en}, 32'd0);
        oe_seen = 1'b0;
        send_hdr(8'h03, 16'h0000);
        byte_xfer(8'h00, d);
        chk("R1 no start without select fall", {31'd0, oe_seen}, 32'd0);
        chk("R1 still standby", {31'd0, standby}, 32'd1);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    // R2 R3 R4 R7: byte mode
    task automatic t_byte_mode();
        logic [7:0] d;
        rdsr_check("R7 status default", 8'h02);
        wr_bytes(16'h0124, 1, 32'h11000000);
        wr_bytes(16'h0123, 2, 32'hA53C0000);
        rd_check("R3 R2 byte write/read", 16'h0123, 1, 32'hA5000000);
        rd_check("R4 extra byte not written", 16'h0124, 1, 32'h11000000);
        rd_check("R2 upper address bits ignored", 16'hF923, 1, 32'hA5000000);
        cs_on();
        send_hdr(8'h03, 16'h0123);
        byte_xfer(8'h00, d);
        oe_seen = 1'b0;
        byte_xfer(8'h00, d);
        chk("R4 no drive after one byte", {31'd0, oe_seen}, 32'd0);
        cs_off();
    endtask

    // R8: undefined opcode
    task automatic t_unknown();
        logic [7:0] d;
        cs_on();
        oe_seen = 1'b0;
        byte_xfer(8'h0A, d);
        send_hdr(8'h02, 16'h0123);
        byte_xfer(8'hFF, d);
        chk("R8 oe stays low", {31'd0, oe_seen}, 32'd0);
        cs_off();
        rd_check("R8 memory unchanged", 16'h0123, 1, 32'hA5000000);
    endtask

    // R5 R7: page mode
    task automatic t_page();
        wrsr(8'h80);
        rdsr_check("R7 status after write", 8'h82);
        wr_bytes(16'h005E, 3, 32'h51525300);
        rd_check("R5 write wrapped to page start", 16'h0040, 1, 32'h53000000);
        rd_check("R5 read wraps in page", 16'h005E, 3, 32'h51525300);
    endtask

    // R6: sequential mode
    task automatic t_seq();
        wrsr(8'h40);
        wr_bytes(16'h07FE, 3, 32'h61626300);
        rd_check("R6 rollover to 0", 16'h07FF, 2, 32'h62630000);
        wr_bytes(16'h013F, 2, 32'h71720000);
        rd_check("R6 page crossing", 16'h013F, 2, 32'h71720000);
    endtask

    // R9: pause entered and left with clock low
    task automatic t_hold();
        logic [7:0] d, d2;
        logic b;
        cs_on();
        send_hdr(8'h03, 16'h013F);
        for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        pause_n = 1'b0;
        wait_clk(H);
        chk("R9 oe off in pause", {31'd0, ser_out_en}, 32'd0);
        repeat (3) begin ser_clk = 1'b1; wait_clk(H); ser_clk = 1'b0; wait_clk(H); end
        pause_n = 1'b1;
        wait_clk(H);
        for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        byte_xfer(8'h00, d2);
        chk("R9 byte resumes intact", {24'd0, d}, 32'h71);
        chk("R9 next byte", {24'd0, d2}, 32'h72);
        cs_off();
    endtask

    // R10: pause requested with clock high
    task automatic t_hold_deferred();
        logic [7:0] d;
        logic b;
        cs_on();
        send_hdr(8'h03, 16'h013F);
        for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        ser_in = 1'b0;
        wait_clk(H);
        d[4] = ser_out;
        ser_clk = 1'b1;
        wait_clk(H);
        pause_n = 1'b0;
        wait_clk(H);
        chk("R10 pause deferred while clock high", {31'd0, ser_out_en}, 32'd1);
        ser_clk = 1'b0;
        wait_clk(H);
        chk("R10 pause active after fall", {31'd0, ser_out_en}, 32'd0);
        repeat (2) begin ser_clk = 1'b1; wait_clk(H); ser_clk = 1'b0; wait_clk(H); end
        pause_n = 1'b1;
        wait_clk(H);
        for (int i = 3; i >= 0; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        chk("R10 byte intact after deferred pause", {24'd0, d}, 32'h71);
        cs_off();
    endtask

    // R11: pause disabled by status bit 0
    task automatic t_hold_off();
        logic [7:0] d, d2;
        logic b;
        wrsr(8'h41);
        rdsr_check("R7 status bit0 readback", 8'h43);
        cs_on();
        send_hdr(8'h03, 16'h013F);
        for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        pause_n = 1'b0;
        wait_clk(H);
        chk("R11 oe stays on", {31'd0, ser_out_en}, 32'd1);
        for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        byte_xfer(8'h00, d2);
        chk("R11 data with pause ignored", {24'd0, d}, 32'h71);
        chk("R11 second byte", {24'd0, d2}, 32'h72);
        pause_n = 1'b1;
        cs_off();
    endtask

    // R12: deselect mid-read
    task automatic t_deselect();
        logic b;
        wrsr(8'h00);
        cs_on();
        send_hdr(8'h03, 16'h0123);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, b);
        chk("R2 oe on during data", {31'd0, ser_out_en}, 32'd1);
        sel_n = 1'b1;
        wait_clk(5);
        chk("R12 oe off after deselect", {31'd0, ser_out_en}, 32'd0);
        chk("R12 standby after deselect", {31'd0, standby}, 32'd1);
        wait_clk(5);
    endtask

    initial begin
        t_reset();
        t_byte_mode();
        t_unknown();
        t_page();
        t_seq();
        t_hold();
        t_hold_deferred();
        t_hold_off();
        t_deselect();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule